// File: doc/BRIEF.md
# Active-Low Gamepad Input Merger

This block builds one 8-bit button byte for a host processor. The byte is active low: a zero bit means that button is held. The byte comes from two sources. The first is an external pad that holds its buttons in a shift register. The block drives that pad's latch and clock pins and reads its serial data line. The second source is a parallel byte from another controller bridge. Its decoding happens elsewhere. The two sources are combined with a bitwise AND, so a press on either source shows as a zero.

Capture is tied to the vertical sync interval. A rising edge on `vsync` starts one latch pulse and then eight clock pulses. The presented byte is replaced only when that whole sequence has finished while `vsync` is still high. A long hold on Start raises a reset request for the host system.

Top module: `pad_merge`

## Requirements
- R1: Bit meaning of `pad_byte`, with 0 meaning pressed: bit 7 A, bit 6 B, bit 5 Select, bit 4 Start, bit 3 Up, bit 2 Down, bit 1 Left, bit 0 Right.
- R2: A rising edge of `vsync` starts the following sequence. First, `pad_latch` is high for HALF_CYC cycles. Then come eight slots. Each slot is `pad_clk` low for HALF_CYC cycles and then high for HALF_CYC cycles. Outside this sequence, both pins stay low, and the two pins are never high together.
- R3: `pad_data` is sampled in the last cycle of each low phase. The first sample taken after the latch lands in bit 7, so bits are shifted in MSB first.
- R4: At the end of the sequence, `pad_byte` is loaded with the serial byte AND `ext_byte`. `ext_byte` is read in the final cycle of the sequence.
- R5: `pad_byte` changes only when a full sequence completes with `vsync` still high. If `vsync` falls before that point, the sequence is dropped, the pins return low, and `pad_byte` keeps its old value.
- R6: `reset_req` rises at the completion of the HOLD_FRAMES-th consecutive capture that has bit 4 (Start) at 0. The default for HOLD_FRAMES is 120.
- R7: `reset_req` falls at the first completed capture that has bit 4 at 1. A dropped sequence neither advances nor clears the hold count.
- R8: After reset, `pad_byte` is 8'hFF, and `pad_latch`, `pad_clk` and `reset_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync | input | 1 | High during the vertical sync interval |
| pad_data | input | 1 | Serial data from the external pad |
| ext_byte | input | 8 | Active-low button byte from other sources |
| pad_latch | output | 1 | Latch pin to the external pad |
| pad_clk | output | 1 | Shift clock pin to the external pad |
| pad_byte | output | 8 | Merged active-low button byte |
| reset_req | output | 1 | Long-hold Start reset request |

## Verification
The bench models the external pad as a shift register that loads on latch and shifts on each clock rise.

Directed stimulus covers three input patterns:
- A single pressed bit on the serial side walks through all eight positions. This catches wrong bit order or an off-by-one shift.
- A single pressed bit on the parallel side does the same walk. This separates the AND merge from the serial path.
- Random pairs of bytes check the merge of the two sources.

A short `vsync` pulse, placed inside a long Start hold, shows three things: a dropped capture leaves the byte unchanged, the hold count is neither advanced nor cleared, and the request rises exactly on the 120th completed frame.

// File: rtl/pad_merge.sv
module pad_merge #(
  parameter int HALF_CYC    = 4,
  parameter int HOLD_FRAMES = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync,
  input  logic       pad_data,
  input  logic [7:0] ext_byte,
  output logic       pad_latch,
  output logic       pad_clk,
  output logic [7:0] pad_byte,
  output logic       reset_req
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam int HW = $clog2(HOLD_FRAMES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_LOW, S_HIGH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          vs_q;
  logic [HW-1:0] hold;

  wire        phase_end = (cnt == CW'(HALF_CYC - 1));
  wire [7:0]  merged    = shreg & ext_byte;

  assign pad_latch = (st == S_LATCH);
  assign pad_clk   = (st == S_HIGH);
  assign reset_req = (hold == HW'(HOLD_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= 8'hFF;
      vs_q     <= 1'b0;
      pad_byte <= 8'hFF;
      hold     <= '0;
    end else begin
      vs_q <= vsync;
      if (st == S_IDLE) begin
        if (vsync && !vs_q) begin
          st  <= S_LATCH;
          cnt <= '0;
        end
      end else if (!vsync) begin
        st <= S_IDLE;
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (st)
          S_LATCH: begin
            st  <= S_LOW;
            idx <= '0;
          end
          S_LOW: begin
            shreg <= {shreg[6:0], pad_data};
            st    <= S_HIGH;
          end
          S_HIGH: begin
            if (idx == 3'd7) begin
              st       <= S_IDLE;
              pad_byte <= merged;
              if (merged[4])
                hold <= '0;
              else if (hold != HW'(HOLD_FRAMES))
                hold <= hold + 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_LOW;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module pad_merge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync,
  input logic       pad_latch,
  input logic       pad_clk,
  input logic [7:0] pad_byte,
  input logic       reset_req
);
  a_r2_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_latch && pad_clk));

  a_r2_pins_need_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_latch || pad_clk) |-> $past(vsync));

  a_r5_byte_held_outside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(pad_byte));

  a_r6_req_implies_start: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !pad_byte[4]);

  a_r7_req_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> pad_byte[4]);
endmodule

bind pad_merge pad_merge_chk u_pad_merge_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .pad_latch(pad_latch),
  .pad_clk(pad_clk), .pad_byte(pad_byte), .reset_req(reset_req)
);

// File: tb/pad_merge_bench.sv
module pad_merge_bench;
  localparam int HALF = 4;
  localparam int HOLD = 120;
  localparam int SEQ  = 17 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic       pad_data;
  logic [7:0] ext_byte = 8'hFF;
  logic       pad_latch, pad_clk, reset_req;
  logic [7:0] pad_byte;

  int tests = 0;
  int fails = 0;

  logic [7:0] ctrl_btn = 8'hFF;
  logic [7:0] sr = 8'hFF;
  logic       clk_q = 1'b0;
  int         lat_cyc = 0, clk_rises = 0;
  logic       pclk_prev = 1'b0;

  logic [7:0] exp_byte = 8'hFF;
  int         exp_hold = 0;

  always #10 clk = ~clk;

  pad_merge #(.HALF_CYC(HALF), .HOLD_FRAMES(HOLD)) u_pad_merge (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .pad_data(pad_data),
    .ext_byte(ext_byte), .pad_latch(pad_latch), .pad_clk(pad_clk),
    .pad_byte(pad_byte), .reset_req(reset_req)
  );

  assign pad_data = sr[7];
  always @(posedge clk) begin
    clk_q <= pad_clk;
    if (pad_latch) sr <= ctrl_btn;
    else if (pad_clk && !clk_q) sr <= {sr[6:0], 1'b1};
  end

  always @(negedge clk) begin
    if (pad_latch) lat_cyc++;
    if (pad_clk && !pclk_prev) clk_rises++;
    pclk_prev = pad_clk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] merge_exp(logic [7:0] a, logic [7:0] b);
    return a & b;
  endfunction

  function automatic int next_hold(int h, logic [7:0] m);
    if (m[4]) return 0;
    return (h < HOLD) ? h + 1 : h;
  endfunction

  task automatic frame(logic [7:0] btn, logic [7:0] ext, int hi);
    @(negedge clk);
    ctrl_btn = btn;
    ext_byte = ext;
    lat_cyc = 0;
    clk_rises = 0;
    vsync = 1'b1;
    repeat (hi) @(negedge clk);
    vsync = 1'b0;
    repeat (12) @(negedge clk);
    if (hi > SEQ) begin
      exp_byte = merge_exp(btn, ext);
      exp_hold = next_hold(exp_hold, exp_byte);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    check("R8 byte", pad_byte, 8'hFF);
    check("R8 pins", {pad_latch, pad_clk, reset_req}, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    ctrl_btn = 8'h00;
    ext_byte = 8'h00;
    repeat (30) @(negedge clk);
    check("R5 no vsync keeps byte", pad_byte, 8'hFF);
    check("R2 pins idle", {pad_latch, pad_clk}, 2'b00);

    for (int i = 0; i < 8; i++) begin
      frame(~(8'h80 >> i), 8'hFF, 80);
      check("R3 serial bit order", pad_byte, exp_byte);
      check("R2 latch width", lat_cyc, HALF);
      check("R2 clock pulses", clk_rises, 8);
    end
    frame(8'h7F, 8'hFF, 80);
    check("R1 button A is bit 7", pad_byte[7], 1'b0);

    for (int i = 0; i < 8; i++) begin
      frame(8'hFF, ~(8'h01 << i), 80);
      check("R4 parallel bit", pad_byte, exp_byte);
    end

    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom) | 8'h10;
      b = 8'($urandom) | 8'h10;
      frame(a, b, 80);
      check("R4 random merge", pad_byte, exp_byte);
    end

    frame(8'h00, 8'h00, 40);
    check("R5 aborted capture", pad_byte, exp_byte);
    check("R5 abort pins low", {pad_latch, pad_clk}, 2'b00);

    for (int i = 0; i < 60; i++) frame(8'(($urandom) & 8'hEF), 8'hFF, 80);
    check("R6 no early request", reset_req, 1'b0);
    frame(8'hEF, 8'hFF, 40);
    check("R7 abort keeps count", reset_req, 1'b0);
    for (int i = 0; i < 59; i++) frame(8'hFF, 8'(($urandom) & 8'hEF), 80);
    check("R6 119 frames no request", reset_req, 1'b0);
    check("R6 model count", exp_hold, 119);
    frame(8'hEF, 8'hEF, 80);
    check("R6 request at 120", reset_req, 1'b1);
    frame(8'h6F, 8'hFF, 80);
    check("R6 request stays", reset_req, 1'b1);
    frame(8'hFF, 8'hFF, 40);
    check("R7 abort keeps request", reset_req, 1'b1);
    frame(8'hFF, 8'hFF, 80);
    check("R7 release drops request", reset_req, 1'b0);
    check("R1 idle byte", pad_byte, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule